// File: doc/BRIEF.md
# Cache Array Access Port

This block gives software direct access to the tag store and the line store of a direct-mapped, write-back data cache. Accesses come in on a simple valid/ready register bus as a 32-bit address and a 32-bit data word. The top address byte picks the target: one code opens the tag store and another opens the line store. The entry index and the longword within a line come from fixed fields lower in the address.

A tag access can be plain or associative. A plain write replaces the tag, dirty flag and valid flag of the indexed entry without any condition. An associative write first compares the entry's stored tag with a compare tag. It changes the flags only when that compare hits a valid entry, so software can invalidate or clean one line by address.

When an update would discard a dirty line, the block first asks an external eviction port to write the line back. It holds the bus until that port reports completion. Address translation sits outside this block: a translated tag and a translation-miss flag arrive on input pins, and a control input chooses between that tag and the tag carried in the data word.

Top module: `cap_array_port`

## Requirements
- R1: The address byte [31:24] selects the target: 0xF4 is the tag store and 0xF5 is the line store. A request with any other selector completes in the cycle it is presented, returns 0 and changes no state.
- R2: The entry index is the IDX_W address bits starting at bit 5 (bits [13:5] for 512 entries). Address bits above the index and below bit 24 do not affect which entry is reached.
- R3: A tag-store read returns the stored tag in bits [31:10], the dirty flag in bit 1 and the valid flag in bit 0. Bits [9:2] read as zero.
- R4: A tag-store write with address bit 3 = 0 stores data bits [31:10] as the tag, data bit 1 as dirty and data bit 0 as valid into the indexed entry. Data bits [9:2] are ignored.
- R5: A tag-store write with address bit 3 = 1 is a hit when the compare tag equals the stored tag, the stored valid flag is 1 and no translation miss applies. On a hit the written dirty and valid bits are stored and the stored tag is kept.
- R6: An associative write that does not hit (tag mismatch, stored valid 0, or a translation miss while translation is enabled) completes without error, leaves the entry unchanged and raises no eviction.
- R7: The compare tag is data bits [31:10] when xlat_en is 0 and xlat_tag when xlat_en is 1. xlat_miss has effect only when xlat_en is 1.
- R8: An eviction request is raised, carrying the entry's index and its old tag, in two cases: an associative hit on a dirty entry that writes 0 to dirty or to valid, and a plain write over an entry that is both valid and dirty. No other access raises one.
- R9: While evict_req is high, req_ready stays low and the eviction index and tag hold steady. evict_req stays high until evict_done is sampled. The entry is updated in the cycle after that, when req_ready rises.
- R10: A line-store access reads or writes the 32-bit longword picked by address bits [4:2]. An access with address bits [1:0] not zero returns 0 and writes nothing.
- R11: Reads of either store complete in the cycle they are presented, with req_ready high combinationally.
- R12: After reset every tag entry reads as tag 0, clean and invalid, and every longword reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data word |
| req_ready | output | 1 | Request completes at this clock edge |
| rsp_rdata | output | 32 | Read data, valid while a read completes |
| xlat_en | input | 1 | Use the translated tag for associative compares |
| xlat_tag | input | TAG_W | Translated compare tag |
| xlat_miss | input | 1 | Translation found no mapping |
| evict_req | output | 1 | Write-back of a dirty line requested |
| evict_idx | output | IDX_W | Index of the line to write back |
| evict_tag | output | TAG_W | Tag the line held before the update |
| evict_done | input | 1 | Eviction finished (one-cycle pulse) |

## Verification
The bound checker watches, on every cycle, the eviction handshake: ready stays low and the eviction fields hold steady while a write-back is pending, and an eviction starts only after a tag-store write. It also checks that reads and foreign-selector requests complete at once and that the reserved read bits stay zero. Whether a given access should hit, should store its flags, or should raise a write-back depends on the stored entry. Only the bench can show that. It sweeps every combination of stored flags, written flags, tag match and translation mode on each entry of a small configuration, and compares the results with a reference array. The same holds for index aliasing and longword placement.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVICT,
      ST_COMMIT
   } cap_state_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_TAG_RD,
      OP_TAG_WR,
      OP_TAG_ASSOC,
      OP_DAT_RD,
      OP_DAT_WR
   } cap_op_e;

endpackage

// File: rtl/cap_decode.sv
module cap_decode
   import cap_pkg::*;
#(
   parameter int        IDX_W     = 9,
   parameter int        IDX_LSB   = 5,
   parameter int        WSEL_W    = 3,
   parameter int        ASSOC_BIT = 3,
   parameter logic [7:0] SEL_TAG  = 8'hF4,
   parameter logic [7:0] SEL_DATA = 8'hF5
) (
   input  logic              req_write,
   input  logic [31:0]       addr,
   output cap_op_e           op,
   output logic [IDX_W-1:0]  idx,
   output logic [WSEL_W-1:0] word
);

   logic [7:0] sel;
   logic       unused_addr;

   assign sel         = addr[31:24];
   assign idx         = addr[IDX_LSB +: IDX_W];
   assign word        = addr[2 +: WSEL_W];
   assign unused_addr = ^addr;

   always_comb begin
      op = OP_NONE;
      if (sel == SEL_TAG) begin
         if (!req_write)           op = OP_TAG_RD;
         else if (addr[ASSOC_BIT]) op = OP_TAG_ASSOC;
         else                      op = OP_TAG_WR;
      end else if (sel == SEL_DATA && addr[1:0] == 2'b00) begin
         op = req_write ? OP_DAT_WR : OP_DAT_RD;
      end
   end

endmodule

// File: rtl/cap_tag_store.sv
module cap_tag_store #(
   parameter int IDX_W = 9,
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_u,
   output logic             rd_v,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_u,
   input  logic             wr_v
);

   localparam int ENTRIES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic [ENTRIES-1:0] u_q;
   logic [ENTRIES-1:0] v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
         u_q <= '0;
         v_q <= '0;
      end else if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         u_q[wr_idx]   <= wr_u;
         v_q[wr_idx]   <= wr_v;
      end
   end

   assign rd_tag = tag_q[rd_idx];
   assign rd_u   = u_q[rd_idx];
   assign rd_v   = v_q[rd_idx];

endmodule

// File: rtl/cap_data_store.sv
module cap_data_store #(
   parameter int   IDX_W      = 9,
   parameter int   WSEL_W     = 3,
   parameter int   DATA_W     = 32,
   parameter logic DATA_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WSEL_W-1:0] word,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int ENTRIES = 1 << IDX_W;
   localparam int WORDS   = 1 << WSEL_W;

   logic [DATA_W-1:0] lane_rd [WORDS];

   for (genvar l = 0; l < WORDS; l++) begin : g_lane
      logic [DATA_W-1:0] mem [ENTRIES];
      logic              lane_we;

      assign lane_we = wr_en && (word == WSEL_W'(l));

      if (DATA_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
            end else if (lane_we) begin
               mem[idx] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (lane_we) mem[idx] <= wr_data;
         end
      end

      assign lane_rd[l] = mem[idx];
   end

   assign rd_data = lane_rd[word];

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_pkg::*;
#(
   parameter int IDX_W = 9,
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  cap_op_e          op,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] w_tag,
   input  logic             w_u,
   input  logic             w_v,
   input  logic [TAG_W-1:0] cmp_tag,
   input  logic             cmp_miss,
   input  logic [TAG_W-1:0] st_tag,
   input  logic             st_u,
   input  logic             st_v,
   input  logic             evict_done,
   output logic             req_ready,
   output logic             tag_we,
   output logic [IDX_W-1:0] tag_widx,
   output logic [TAG_W-1:0] tag_wtag,
   output logic             tag_wu,
   output logic             tag_wv,
   output logic             data_we,
   output logic             evict_req,
   output logic [IDX_W-1:0] evict_idx,
   output logic [TAG_W-1:0] evict_tag
);

   cap_state_e       state_q, state_d;
   logic [IDX_W-1:0] pend_idx_q;
   logic [TAG_W-1:0] pend_tag_q, old_tag_q;
   logic             pend_u_q, pend_v_q;

   logic             hit, act, need_wb;
   logic [TAG_W-1:0] new_tag;

   always_comb begin
      hit     = (st_tag == cmp_tag) && st_v && !cmp_miss;
      act     = 1'b0;
      need_wb = 1'b0;
      new_tag = w_tag;
      case (op)
         OP_TAG_WR: begin
            act     = 1'b1;
            need_wb = st_v && st_u;
         end
         OP_TAG_ASSOC: begin
            act     = hit;
            need_wb = hit && st_u && (!w_u || !w_v);
            new_tag = st_tag;
         end
         default: ;
      endcase
   end

   always_comb begin
      state_d   = state_q;
      req_ready = 1'b0;
      tag_we    = 1'b0;
      tag_widx  = idx;
      tag_wtag  = new_tag;
      tag_wu    = w_u;
      tag_wv    = w_v;
      data_we   = 1'b0;
      evict_req = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (need_wb) begin
                  state_d = ST_EVICT;
               end else begin
                  req_ready = 1'b1;
                  tag_we    = act;
                  data_we   = (op == OP_DAT_WR);
               end
            end
         end
         ST_EVICT: begin
            evict_req = 1'b1;
            if (evict_done) state_d = ST_COMMIT;
         end
         ST_COMMIT: begin
            req_ready = 1'b1;
            tag_we    = 1'b1;
            tag_widx  = pend_idx_q;
            tag_wtag  = pend_tag_q;
            tag_wu    = pend_u_q;
            tag_wv    = pend_v_q;
            state_d   = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign evict_idx = pend_idx_q;
   assign evict_tag = old_tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pend_idx_q <= '0;
         pend_tag_q <= '0;
         old_tag_q  <= '0;
         pend_u_q   <= 1'b0;
         pend_v_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid && need_wb) begin
            pend_idx_q <= idx;
            pend_tag_q <= new_tag;
            old_tag_q  <= st_tag;
            pend_u_q   <= w_u;
            pend_v_q   <= w_v;
         end
      end
   end

endmodule

// File: rtl/cap_array_port.sv
module cap_array_port
   import cap_pkg::*;
#(
   parameter int         IDX_W      = 9,
   parameter int         IDX_LSB    = 5,
   parameter int         TAG_LSB    = 10,
   parameter int         DATA_W     = 32,
   parameter logic [7:0] SEL_TAG    = 8'hF4,
   parameter logic [7:0] SEL_DATA   = 8'hF5,
   parameter logic       DATA_RESET = 1'b1,
   localparam int        TAG_W      = DATA_W - TAG_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       rsp_rdata,
   input  logic              xlat_en,
   input  logic [TAG_W-1:0]  xlat_tag,
   input  logic              xlat_miss,
   output logic              evict_req,
   output logic [IDX_W-1:0]  evict_idx,
   output logic [TAG_W-1:0]  evict_tag,
   input  logic              evict_done
);

   localparam int WSEL_W    = IDX_LSB - 2;
   localparam int ASSOC_BIT = 3;

   if (DATA_W != 32) begin : g_bad_width
      $error("cap_array_port: DATA_W must be 32");
   end
   if (IDX_LSB + IDX_W > 24) begin : g_bad_index
      $error("cap_array_port: index field overlaps the selector byte");
   end
   if (IDX_LSB <= ASSOC_BIT) begin : g_bad_lsb
      $error("cap_array_port: index must sit above the association bit");
   end
   if (TAG_LSB < 3 || TAG_LSB >= DATA_W) begin : g_bad_tag
      $error("cap_array_port: tag field position out of range");
   end

   cap_op_e           op;
   logic [IDX_W-1:0]  idx;
   logic [WSEL_W-1:0] word;
   logic [TAG_W-1:0]  st_tag, cmp_tag, tag_wtag;
   logic              st_u, st_v, tag_we, tag_wu, tag_wv, data_we, cmp_miss;
   logic [IDX_W-1:0]  tag_widx;
   logic [DATA_W-1:0] dat_rd;
   logic              unused_wdata;

   assign cmp_tag      = xlat_en ? xlat_tag : req_wdata[DATA_W-1:TAG_LSB];
   assign cmp_miss     = xlat_en && xlat_miss;
   assign unused_wdata = ^req_wdata[TAG_LSB-1:2];

   cap_decode #(
      .IDX_W     (IDX_W),
      .IDX_LSB   (IDX_LSB),
      .WSEL_W    (WSEL_W),
      .ASSOC_BIT (ASSOC_BIT),
      .SEL_TAG   (SEL_TAG),
      .SEL_DATA  (SEL_DATA)
   ) u_decode (
      .req_write (req_write),
      .addr      (req_addr),
      .op        (op),
      .idx       (idx),
      .word      (word)
   );

   cap_tag_store #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (idx),
      .rd_tag (st_tag),
      .rd_u   (st_u),
      .rd_v   (st_v),
      .wr_en  (tag_we),
      .wr_idx (tag_widx),
      .wr_tag (tag_wtag),
      .wr_u   (tag_wu),
      .wr_v   (tag_wv)
   );

   cap_data_store #(
      .IDX_W      (IDX_W),
      .WSEL_W     (WSEL_W),
      .DATA_W     (DATA_W),
      .DATA_RESET (DATA_RESET)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .word    (word),
      .wr_en   (data_we),
      .wr_data (req_wdata),
      .rd_data (dat_rd)
   );

   cap_ctrl #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .op         (op),
      .idx        (idx),
      .w_tag      (req_wdata[DATA_W-1:TAG_LSB]),
      .w_u        (req_wdata[1]),
      .w_v        (req_wdata[0]),
      .cmp_tag    (cmp_tag),
      .cmp_miss   (cmp_miss),
      .st_tag     (st_tag),
      .st_u       (st_u),
      .st_v       (st_v),
      .evict_done (evict_done),
      .req_ready  (req_ready),
      .tag_we     (tag_we),
      .tag_widx   (tag_widx),
      .tag_wtag   (tag_wtag),
      .tag_wu     (tag_wu),
      .tag_wv     (tag_wv),
      .data_we    (data_we),
      .evict_req  (evict_req),
      .evict_idx  (evict_idx),
      .evict_tag  (evict_tag)
   );

   always_comb begin
      case (op)
         OP_TAG_RD: rsp_rdata = {st_tag, {(TAG_LSB-2){1'b0}}, st_u, st_v};
         OP_DAT_RD: rsp_rdata = dat_rd;
         default:   rsp_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
   parameter logic [7:0] SEL_TAG  = 8'hF4,
   parameter logic [7:0] SEL_DATA = 8'hF5,
   parameter int         IDX_W    = 9,
   parameter int         TAG_W    = 22,
   parameter int         TAG_LSB  = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [7:0]       sel,
   input logic             req_ready,
   input logic [31:0]      rsp_rdata,
   input logic             evict_req,
   input logic [IDX_W-1:0] evict_idx,
   input logic [TAG_W-1:0] evict_tag,
   input logic             evict_done
);

   AST_EVICT_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      evict_req |-> !req_ready); // R9

   AST_EVICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      evict_req && !evict_done |=> evict_req); // R9

   AST_EVICT_FIELDS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      evict_req && !evict_done |=> $stable(evict_idx) && $stable(evict_tag)); // R9

   AST_EVICT_FROM_TAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evict_req) |-> $past(req_valid && req_write && sel == SEL_TAG)); // R8

   AST_TAG_READ_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write && sel == SEL_TAG
      |-> rsp_rdata[TAG_LSB-1:2] == '0); // R3

   AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !evict_req && sel != SEL_TAG && sel != SEL_DATA
      |-> req_ready && rsp_rdata == '0); // R1

   AST_READ_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && !evict_req |-> req_ready); // R11

endmodule

bind cap_array_port cap_checker #(
   .SEL_TAG  (SEL_TAG),
   .SEL_DATA (SEL_DATA),
   .IDX_W    (IDX_W),
   .TAG_W    (TAG_W),
   .TAG_LSB  (TAG_LSB)
) u_cap_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .sel        (req_addr[31:24]),
   .req_ready  (req_ready),
   .rsp_rdata  (rsp_rdata),
   .evict_req  (evict_req),
   .evict_idx  (evict_idx),
   .evict_tag  (evict_tag),
   .evict_done (evict_done)
);

// File: tb/tb_cap_array_port.sv
module tb_cap_array_port;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 3;
   localparam int ENT        = 1 << IDX_W;
   localparam int WORDS      = 8;
   localparam int TAG_W      = 22;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]      req_addr = '0, req_wdata = '0;
   logic             req_ready;
   logic [31:0]      rsp_rdata;
   logic             xlat_en = 1'b0, xlat_miss = 1'b0;
   logic [TAG_W-1:0] xlat_tag = '0;
   logic             evict_req;
   logic [IDX_W-1:0] evict_idx;
   logic [TAG_W-1:0] evict_tag;
   logic             evict_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_array_port #(.IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_rdata(rsp_rdata), .xlat_en(xlat_en), .xlat_tag(xlat_tag),
      .xlat_miss(xlat_miss), .evict_req(evict_req), .evict_idx(evict_idx),
      .evict_tag(evict_tag), .evict_done(evict_done)
   );

   int n_chk = 0, n_bad = 0;
   bit reported = 0;

   logic [TAG_W-1:0] m_tag [ENT];
   bit               m_u [ENT];
   bit               m_v [ENT];
   logic [31:0]      m_dat [ENT][WORDS];

   logic [31:0]      last_rd;
   int               last_nev, last_iters;
   logic [IDX_W-1:0] last_eidx;
   logic [TAG_W-1:0] last_etag;

   task automatic check(string rq, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, got, exp);
      end
   endtask

   function automatic logic [31:0] tag_addr(int idx, bit assoc, int hi);
      return 32'hF400_0000 | ((32'(hi) & 32'hFFFF) << 8) | (32'(idx) << 5) | (32'(assoc) << 3);
   endfunction

   function automatic logic [31:0] dat_addr(int idx, int w, int hi);
      return 32'hF500_0000 | ((32'(hi) & 32'hFFFF) << 8) | (32'(idx) << 5) | (32'(w) << 2);
   endfunction

   task automatic access(bit wr, logic [31:0] a, logic [31:0] d);
      int  waits;
      bit  fin;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      last_nev = 0; last_iters = 0; waits = 0; fin = 0;
      while (!fin) begin
         #1;
         last_iters++;
         if (req_ready) begin
            last_rd = rsp_rdata;
            fin = 1;
            check("R9 ready with eviction pending", 32'(evict_req), 32'd0);
         end else if (evict_req) begin
            if (waits == 0) begin
               last_nev++;
               last_eidx = evict_idx;
               last_etag = evict_tag;
            end
            waits++;
            if (waits == 3) evict_done = 1'b1;
         end
         if (last_iters > 200) begin
            n_chk++; n_bad++;
            $display("FAIL R9: access hung, actual no ready expected ready");
            fin = 1;
         end
         @(negedge clk);
         evict_done = 1'b0;
      end
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic tag_read_check(int i, string rq);
      access(1'b0, tag_addr(i, 1'b0, i * 5), 32'h0);
      check(rq, last_rd, {m_tag[i], 8'h00, m_u[i], m_v[i]});
      check("R11 read latency", 32'(last_iters), 32'd1);
   endtask

   task automatic tag_write(bit assoc, int i, logic [TAG_W-1:0] t, bit u, bit v,
                            bit xen, logic [TAG_W-1:0] xt, bit xm, string rq);
      logic [TAG_W-1:0] cmp, ntag;
      bit hit, wb, act;
      cmp = xen ? xt : t;
      if (!assoc) begin
         act = 1; wb = m_v[i] && m_u[i]; ntag = t;
      end else begin
         hit  = (cmp == m_tag[i]) && m_v[i] && !(xen && xm);
         act  = hit; wb = hit && m_u[i] && (!u || !v); ntag = m_tag[i];
      end
      xlat_en = xen; xlat_tag = xt; xlat_miss = xm;
      access(1'b1, tag_addr(i, assoc, i + 3), {t, 8'b1011_0110, u, v});
      check({rq, " R8 eviction count"}, 32'(last_nev), 32'(wb));
      if (wb) begin
         check("R8 eviction index", 32'(last_eidx), 32'(i));
         check("R8 eviction old tag", 32'(last_etag), 32'(m_tag[i]));
         check("R9 update waits for done", 32'(last_iters >= 5), 32'd1);
      end
      if (act) begin
         m_tag[i] = ntag; m_u[i] = u; m_v[i] = v;
      end
      xlat_en = 1'b0; xlat_miss = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!reported) begin
         reported = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin
         m_tag[i] = '0; m_u[i] = 0; m_v[i] = 0;
         for (int w = 0; w < WORDS; w++) m_dat[i][w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: reset contents
      for (int i = 0; i < ENT; i++) begin
         tag_read_check(i, "R12 reset tag");
         access(1'b0, dat_addr(i, i % WORDS, 0), 32'h0);
         check("R12 reset data", last_rd, 32'h0);
      end

      // R10 and R2: longword sweep, written through one alias, read through another
      for (int i = 0; i < ENT; i++)
         for (int w = 0; w < WORDS; w++) begin
            m_dat[i][w] = 32'hA500_0000 ^ (32'(i) << 12) ^ (32'(w) * 32'h0001_1111);
            access(1'b1, dat_addr(i, w, 32'h15 + i), m_dat[i][w]);
         end
      for (int i = 0; i < ENT; i++)
         for (int w = 0; w < WORDS; w++) begin
            access(1'b0, dat_addr(i, w, 32'hFFF0 - w), 32'h0);
            check("R10 R2 longword readback", last_rd, m_dat[i][w]);
            check("R11 data read latency", 32'(last_iters), 32'd1);
         end

      // R10: misaligned accesses do nothing and return 0
      access(1'b1, dat_addr(2, 5, 0) | 32'h1, 32'hDEAD_BEEF);
      access(1'b0, dat_addr(2, 5, 0), 32'h0);
      check("R10 misaligned write ignored", last_rd, m_dat[2][5]);
      access(1'b0, dat_addr(2, 5, 0) | 32'h2, 32'h0);
      check("R10 misaligned read zero", last_rd, 32'h0);

      // R1: foreign selectors
      access(1'b1, (dat_addr(3, 1, 0) & 32'h00FF_FFFF) | 32'hF600_0000, 32'h1234_5678);
      check("R1 foreign write latency", 32'(last_iters), 32'd1);
      access(1'b0, dat_addr(3, 1, 0), 32'h0);
      check("R1 foreign write ignored", last_rd, m_dat[3][1]);
      access(1'b1, (tag_addr(3, 1'b0, 0) & 32'h00FF_FFFF) | 32'hF300_0000, 32'hFFFF_FFFF);
      tag_read_check(3, "R1 foreign tag write ignored");
      access(1'b0, (dat_addr(3, 1, 0) & 32'h00FF_FFFF) | 32'h7500_0000, 32'h0);
      check("R1 foreign read zero", last_rd, 32'h0);

      // R4 R3: plain writes over clean entries, then over dirty ones
      for (int i = 0; i < ENT; i++) begin
         tag_write(1'b0, i, 22'(32'h2_A5A5 + i * 32'h1357), 1'b1, 1'b1, 1'b0, '0, 1'b0, "R4 plain first");
         tag_read_check(i, "R4 R3 plain readback");
      end
      for (int i = 0; i < ENT; i++) begin
         tag_write(1'b0, i, 22'(32'h1_0F0F ^ (i * 32'h0777)), i[0], i[1], 1'b0, '0, 1'b0, "R8 plain overwrite");
         tag_read_check(i, "R4 R3 plain second");
      end

      // R5 R6 R7 R8: exhaustive associative sweep
      for (int i = 0; i < ENT; i++)
         for (int sf = 0; sf < 4; sf++)
            for (int m = 0; m < 2; m++)
               for (int nf = 0; nf < 4; nf++)
                  for (int md = 0; md < 3; md++) begin
                     logic [TAG_W-1:0] t, dt, xt;
                     t = 22'(32'h3_1000 + i * 32'h2B1 + sf * 7 + nf * 19 + md);
                     tag_write(1'b0, i, t, sf[1], sf[0], 1'b0, '0, 1'b0, "R8 setup");
                     if (md == 0) begin
                        dt = (m != 0) ? t : (t ^ 22'h1);
                        xt = ~t;
                        tag_write(1'b1, i, dt, nf[1], nf[0], 1'b0, xt, 1'b1, "R5 R6 R7 data-tag compare");
                     end else begin
                        dt = ~t;
                        xt = (m != 0) ? t : (t ^ 22'h4);
                        tag_write(1'b1, i, dt, nf[1], nf[0], 1'b1, xt, md == 2, "R5 R6 R7 translated compare");
                     end
                     tag_read_check(i, "R5 R6 associative result");
                  end

      // R10: line store untouched by all tag traffic
      for (int i = 0; i < ENT; i++)
         for (int w = 0; w < WORDS; w++) begin
            access(1'b0, dat_addr(i, w, 0), 32'h0);
            check("R10 lines kept after tag traffic", last_rd, m_dat[i][w]);
         end

      if (!reported) begin
         reported = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end

endmodule